// File: doc/BRIEF.md
# Hotswap Switch Controller

This block is the digital sequencer for an inrush-limited input power switch in a powered device. It watches comparator flags on the voltage across the switch and on the load current, an undervoltage-lockout flag, an enable from the detection and classification logic, and the negotiated power type (Type 1 or Type 2). From these it selects one of four operating modes for the analog switch: open, inrush current limit, fully conducting, or low overload current limit.

Time is measured from a clock-enable tick that the surrounding logic supplies. The block divides this tick down to a millisecond pulse that times the minimum dwell in the inrush and overload modes. The raw tick also qualifies an over-voltage condition before the switch is dropped into overload. While the switch is fully on and the load current is below the signature threshold, the block requests maintain-power-signature pulses so that the supply does not disconnect.

Mode encoding on `mode_o`: 0 = open, 1 = inrush limit, 2 = fully on, 3 = overload limit.

Top module: `hsw_ctrl`

## Requirements
- R1: While reset is asserted, `mode_o` is 0 (open) and `mps_req_o` is 0.
- R2: With `uvlo_i` high, `mode_o` is 0 after the next clock edge from any mode, and stays 0 while `uvlo_i` stays high, even with `en_i` high.
- R3: From mode 0, `mode_o` becomes 1 (inrush) one edge after `en_i` is high with `uvlo_i` low.
- R4: With `type2_i` low, mode 1 moves to mode 2 on the first edge at which `drop_lo_on_i` (drop below the turn-on level) is high, and stays in mode 1 while it is low.
- R5: With `type2_i` high, mode 1 moves to mode 2 only after DWELL_MS milliseconds in mode 1. With `tick_i` high every cycle and `drop_lo_on_i` held high, mode 2 is reached on edge DWELL_MS*TICKS_PER_MS+1 after the edge that entered mode 1.
- R6: Mode 2 moves to mode 3 on the edge that completes OVL_QUAL_TICKS consecutive ticked cycles of `drop_hi_i` high. A cycle with `drop_hi_i` low restarts the count.
- R7: Mode 3 returns to mode 2 only on `drop_lo_ovl_i` (the lower re-entry level). `drop_lo_on_i` has no effect in mode 3.
- R8: Mode 3 also needs DWELL_MS milliseconds of dwell. With `drop_lo_ovl_i` held high from entry and `tick_i` high each cycle, mode 2 is reached on edge DWELL_MS*TICKS_PER_MS+1 after the edge that entered mode 3.
- R9: `mps_req_o` is high exactly when the mode is 2 and `i_low_i` is high. It reacts combinationally to `i_low_i`.
- R10: Lockout clears the dwell and qualification timers. After a lockout, the next inrush dwell and the next overload qualification each take their full length.
- R11: `ms_tick_o` pulses for one cycle once every TICKS_PER_MS cycles in which `tick_i` is high. Cycles with `tick_i` low do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable time base tick |
| uvlo_i | input | 1 | Undervoltage lockout engaged |
| en_i | input | 1 | Switch enable from the classification logic |
| type2_i | input | 1 | Type 2 handshake completed |
| drop_lo_on_i | input | 1 | Switch drop below the turn-on level |
| drop_lo_ovl_i | input | 1 | Switch drop below the overload re-entry level |
| drop_hi_i | input | 1 | Switch drop above the overload level |
| i_low_i | input | 1 | Load current below the signature threshold |
| mode_o | output | 2 | Switch mode: 0 open, 1 inrush, 2 on, 3 overload |
| mps_req_o | output | 1 | Maintain-power-signature request |
| ms_tick_o | output | 1 | Millisecond pulse |

## Verification
The bench builds the block with TICKS_PER_MS=4, OVL_QUAL_TICKS=3 and DWELL_MS=5. At these values a full dwell is 20 ticks and the overload qualification is 3 ticks. This brings the exact edge of each dwell expiry and each overload entry within a few dozen cycles, so those edges can be checked one by one. The small values also let a lockout that lands mid-dwell, and a dip that lands mid-qualification, be followed by a complete, precisely timed restart inside one short scenario.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    HS_OFF    = 2'd0,
    HS_INRUSH = 2'd1,
    HS_ON     = 2'd2,
    HS_OVL    = 2'd3
  } hs_state_e;
endpackage

// File: rtl/hsw_timebase.sv
module hsw_timebase #(
  parameter int TICKS_PER_MS = 100,
  parameter int DWELL_MS     = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic ms_tick_o,
  output logic dwell_done_o
);
  localparam int TW = $clog2(TICKS_PER_MS + 1);
  localparam int MW = $clog2(DWELL_MS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_MS - 1);
  localparam logic [MW-1:0] MS_MAX    = MW'(DWELL_MS);

  logic [TW-1:0] tick_cnt_q;
  logic [MW-1:0] ms_cnt_q;
  logic          ms_pulse;

  assign ms_pulse     = tick_i && (tick_cnt_q == TICK_LAST);
  assign ms_tick_o    = ms_pulse;
  assign dwell_done_o = (ms_cnt_q == MS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
    end else if (clr_i) begin
      tick_cnt_q <= '0;
    end else if (tick_i) begin
      tick_cnt_q <= (tick_cnt_q == TICK_LAST) ? '0 : tick_cnt_q + 1'b1;
    end
  end

  // dwell counter saturates at the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_cnt_q <= '0;
    end else if (clr_i) begin
      ms_cnt_q <= '0;
    end else if (ms_pulse && (ms_cnt_q != MS_MAX)) begin
      ms_cnt_q <= ms_cnt_q + 1'b1;
    end
  end

  p_dwell_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_cnt_q <= MS_MAX);

  p_tick_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_cnt_q <= TICK_LAST);

  generate
    if (TICKS_PER_MS > 1) begin : g_pulse_chk
      p_ms_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_tick_o |=> !ms_tick_o);
    end
  endgenerate
endmodule

// File: rtl/hsw_qual.sv
module hsw_qual #(
  parameter int OVL_QUAL_TICKS = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  input  logic hi_i,
  output logic hit_o
);
  localparam int QW = $clog2(OVL_QUAL_TICKS + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(OVL_QUAL_TICKS - 1);

  logic [QW-1:0] cnt_q;

  // hit on the tick that completes the qualification window
  assign hit_o = arm_i && hi_i && tick_i && (cnt_q == Q_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!(arm_i && hi_i)) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != Q_LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_qual_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Q_LAST);

  p_qual_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_i |=> (cnt_q == '0));
endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
  import hsw_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      uvlo_i,
  input  logic      en_i,
  input  logic      type2_i,
  input  logic      drop_lo_on_i,
  input  logic      drop_lo_ovl_i,
  input  logic      qual_hit_i,
  input  logic      dwell_done_i,
  input  logic      drop_hi_i,
  output hs_state_e state_o,
  output logic      timer_clr_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (uvlo_i) begin
      state_d = HS_OFF;
    end else begin
      unique case (state_q)
        HS_OFF:    if (en_i) state_d = HS_INRUSH;
        HS_INRUSH: if (drop_lo_on_i && (!type2_i || dwell_done_i)) state_d = HS_ON;
        HS_ON:     if (qual_hit_i) state_d = HS_OVL;
        HS_OVL:    if (drop_lo_ovl_i && dwell_done_i) state_d = HS_ON;
        default:   state_d = HS_OFF;
      endcase
    end
  end

  // timers restart on every state entry and during lockout
  assign timer_clr_o = uvlo_i || (state_d != state_q);
  assign state_o     = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_OFF;
    else         state_q <= state_d;
  end

  p_uvlo_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (state_q == HS_OFF));

  p_inrush_from_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_INRUSH && $past(state_q) != HS_INRUSH) |-> ($past(state_q) == HS_OFF));

  p_t2_dwell_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == HS_INRUSH && state_q == HS_ON && $past(type2_i)) |-> $past(dwell_done_i));

  p_ovl_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == HS_ON && state_q == HS_OVL) |-> $past(drop_hi_i));

  p_ovl_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == HS_OVL && state_q == HS_ON) |-> ($past(drop_lo_ovl_i) && $past(dwell_done_i)));
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int TICKS_PER_MS   = 100,
  parameter int OVL_QUAL_TICKS = 14,
  parameter int DWELL_MS       = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       uvlo_i,
  input  logic       en_i,
  input  logic       type2_i,
  input  logic       drop_lo_on_i,
  input  logic       drop_lo_ovl_i,
  input  logic       drop_hi_i,
  input  logic       i_low_i,
  output logic [1:0] mode_o,
  output logic       mps_req_o,
  output logic       ms_tick_o
);
  hs_state_e state;
  logic      timer_clr;
  logic      dwell_done;
  logic      qual_hit;

  hsw_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .uvlo_i       (uvlo_i),
    .en_i         (en_i),
    .type2_i      (type2_i),
    .drop_lo_on_i (drop_lo_on_i),
    .drop_lo_ovl_i(drop_lo_ovl_i),
    .qual_hit_i   (qual_hit),
    .dwell_done_i (dwell_done),
    .drop_hi_i    (drop_hi_i),
    .state_o      (state),
    .timer_clr_o  (timer_clr)
  );

  hsw_timebase #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .DWELL_MS    (DWELL_MS)
  ) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .clr_i       (timer_clr),
    .ms_tick_o   (ms_tick_o),
    .dwell_done_o(dwell_done)
  );

  hsw_qual #(
    .OVL_QUAL_TICKS(OVL_QUAL_TICKS)
  ) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .arm_i (state == HS_ON),
    .hi_i  (drop_hi_i),
    .hit_o (qual_hit)
  );

  assign mode_o    = state;
  assign mps_req_o = (state == HS_ON) && i_low_i;

  p_mps_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd2) |-> !mps_req_o);
endmodule

// File: tb/sim_hsw_ctrl.sv
`timescale 1ns/1ps
module sim_hsw_ctrl;
  localparam int TPM = 4;
  localparam int QT  = 3;
  localparam int DW  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1, uvlo_i = 1'b0, en_i = 1'b0, type2_i = 1'b0;
  logic drop_lo_on_i = 1'b0, drop_lo_ovl_i = 1'b0, drop_hi_i = 1'b0, i_low_i = 1'b0;
  logic [1:0] mode_o;
  logic mps_req_o, ms_tick_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hsw_ctrl #(.TICKS_PER_MS(TPM), .OVL_QUAL_TICKS(QT), .DWELL_MS(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .uvlo_i(uvlo_i), .en_i(en_i),
    .type2_i(type2_i), .drop_lo_on_i(drop_lo_on_i), .drop_lo_ovl_i(drop_lo_ovl_i),
    .drop_hi_i(drop_hi_i), .i_low_i(i_low_i), .mode_o(mode_o),
    .mps_req_o(mps_req_o), .ms_tick_o(ms_tick_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pass n rising edges, end at the following falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_off();
    uvlo_i = 1'b1; en_i = 1'b0; type2_i = 1'b0; drop_lo_on_i = 1'b0;
    drop_lo_ovl_i = 1'b0; drop_hi_i = 1'b0; i_low_i = 1'b0; tick_i = 1'b1;
    edges(1);
    uvlo_i = 1'b0;
    edges(1);
    chk("R2 off", mode_o, 0);
  endtask

  task automatic go_on_t1();
    go_off();
    en_i = 1'b1; drop_lo_on_i = 1'b1;
    edges(1);
    chk("R3 inrush", mode_o, 1);
    edges(1);
    chk("R4 on", mode_o, 2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 mode", mode_o, 0);
    chk("R1 mps", mps_req_o, 0);
    rst_ni = 1'b1;
    edges(1);
  endtask

  task automatic t_lockout();
    go_off();
    uvlo_i = 1'b1; en_i = 1'b1;
    edges(3);
    chk("R2 held", mode_o, 0);
    uvlo_i = 1'b0;
    edges(1);
    chk("R3 enter", mode_o, 1);
  endtask

  task automatic t_type1();
    go_off();
    en_i = 1'b1;
    edges(1);
    chk("R3 enter", mode_o, 1);
    edges(5);
    chk("R4 wait", mode_o, 1);
    drop_lo_on_i = 1'b1;
    edges(1);
    chk("R4 on", mode_o, 2);
  endtask

  task automatic t_type2();
    go_off();
    en_i = 1'b1; type2_i = 1'b1; drop_lo_on_i = 1'b1;
    edges(1);
    chk("R3 enter", mode_o, 1);
    edges(DW * TPM);
    chk("R5 dwell", mode_o, 1);
    edges(1);
    chk("R5 on", mode_o, 2);
  endtask

  task automatic t_qual();
    go_on_t1();
    drop_hi_i = 1'b1;
    edges(QT - 1);
    chk("R6 partial", mode_o, 2);
    drop_hi_i = 1'b0;
    edges(1);
    chk("R6 dip", mode_o, 2);
    drop_hi_i = 1'b1;
    edges(QT - 1);
    chk("R6 restart", mode_o, 2);
    edges(1);
    chk("R6 ovl", mode_o, 3);
  endtask

  task automatic t_ovl_threshold();
    t_qual();
    drop_hi_i = 1'b0; drop_lo_on_i = 1'b1; drop_lo_ovl_i = 1'b0;
    edges(DW * TPM + 10);
    chk("R7 ignore", mode_o, 3);
    drop_lo_ovl_i = 1'b1;
    edges(1);
    chk("R7 exit", mode_o, 2);
  endtask

  task automatic t_ovl_dwell();
    go_on_t1();
    drop_hi_i = 1'b1;
    edges(QT);
    chk("R6 ovl", mode_o, 3);
    drop_hi_i = 1'b0; drop_lo_ovl_i = 1'b1;
    edges(DW * TPM);
    chk("R8 dwell", mode_o, 3);
    edges(1);
    chk("R8 on", mode_o, 2);
  endtask

  task automatic t_mps();
    go_on_t1();
    i_low_i = 1'b1; #1;
    chk("R9 on low", mps_req_o, 1);
    i_low_i = 1'b0; #1;
    chk("R9 on high", mps_req_o, 0);
    go_off();
    en_i = 1'b1; type2_i = 1'b1; i_low_i = 1'b1;
    edges(1); #1;
    chk("R9 inrush", mps_req_o, 0);
    go_on_t1();
    drop_hi_i = 1'b1; i_low_i = 1'b1;
    edges(QT); #1;
    chk("R9 ovl mode", mode_o, 3);
    chk("R9 ovl", mps_req_o, 0);
  endtask

  task automatic t_uvlo_clear();
    go_off();
    en_i = 1'b1; type2_i = 1'b1; drop_lo_on_i = 1'b1;
    edges(1);
    edges(12);
    uvlo_i = 1'b1;
    edges(1);
    chk("R2 abort", mode_o, 0);
    uvlo_i = 1'b0;
    edges(1);
    chk("R10 reenter", mode_o, 1);
    edges(DW * TPM);
    chk("R10 dwell", mode_o, 1);
    edges(1);
    chk("R10 on", mode_o, 2);
    drop_hi_i = 1'b1;
    edges(QT - 1);
    uvlo_i = 1'b1;
    edges(1);
    chk("R2 abort on", mode_o, 0);
    uvlo_i = 1'b0; type2_i = 1'b0;
    edges(1);
    edges(1);
    chk("R10 on again", mode_o, 2);
    edges(QT - 1);
    chk("R10 qual fresh", mode_o, 2);
    edges(1);
    chk("R10 ovl", mode_o, 3);
  endtask

  task automatic t_timebase();
    int pulses;
    go_on_t1();
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      tick_i = 1'b1; #1;
      if (ms_tick_o) pulses++;
      @(negedge clk);
    end
    chk("R11 full rate", pulses, 40 / TPM);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      tick_i = i[0]; #1;
      if (ms_tick_o) pulses++;
      @(negedge clk);
    end
    chk("R11 half rate", pulses, 20 / TPM);
    tick_i = 1'b1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_lockout();
    t_type1();
    t_type2();
    t_qual();
    t_ovl_threshold();
    t_ovl_dwell();
    t_mps();
    t_uvlo_clear();
    t_timebase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule